// File: doc/BRIEF.md
# Sixteen-Line GPIO Port with Edge-Triggered Interrupts

This block is a general-purpose I/O port with sixteen lines, reached through a simple register bus. The bus carries 32-bit data and uses only the low 16 bits. Software programs several per-line registers:

- an output latch;
- a direction register;
- an edge-polarity select;
- an interrupt mask;
- a gate that filters the input read-back.

A pad is driven only while its line is an output. Input pads pass through a synchronizer, and an edge detector watches the synchronized values.

When the chosen edge appears on an unmasked input line, the matching bit of a sticky status register is set. The single level interrupt output stays high while any status bit is set. Software clears status bits by writing ones to them.

Bus reads are combinational: `bus_rdata` reflects `bus_addr` in the same cycle. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After synchronous reset these registers read 0xFFFF: latch (0x04), direction (0x08), polarity (0x0C), mask (0x10) and gate (0x18). Status (0x14) and input (0x00) read 0. `pad_oe` is 0 and `irq` is 0.
- R2: A write to 0x04, 0x08, 0x0C, 0x10 or 0x18 stores `bus_wdata[15:0]`, and a later read of that offset returns it. Read bits 31:16 are always 0.
- R3: `pad_oe[i]` is the inverse of direction bit i, where 1 means input. `pad_out[i]` equals latch bit i while the line is an output and 0 otherwise. Both follow a write in the cycle right after its clock edge, so turning a line into an output shows its stored latch value at once.
- R4: A read of 0x00 returns the synchronized pad inputs ANDed with the gate register. A pad change stable before clock edge k is visible on this read after edge k+1.
- R5: For polarity bit 1 a rising synchronized input edge sets status bit i; for polarity bit 0 a falling edge does. The opposite edge leaves the bit unchanged.
- R6: A status bit is set only for a line whose direction bit is 1 and whose mask bit is 0.
- R7: A write to 0x14 clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R8: `irq` is high exactly when at least one status bit is set.
- R9: When a qualifying edge and a clearing write hit the same status bit at the same clock edge, the bit ends up set.
- R10: A read of any other offset returns 0. Writes to 0x00 or to other offsets change no register.
- R11: A status bit stays set after its input returns to its former level, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; low 16 bits used |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad drive enables |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land on the same status bit at the same clock edge: a new qualifying edge arriving through the synchronizer, and a software write-one-to-clear of that bit.

The bench provokes the clash in a directed way. It changes a pad and issues the clearing write exactly two edges later, so the write meets the edge detector's output. The check passes only if the bit and `irq` remain set afterwards.

Random traffic then mixes clears with pad toggles. A cycle-level model scores every cycle for all of these: the read data, the pad drives and `irq`.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int LINE_CNT    = 16;
    localparam int BUS_DW      = 32;
    localparam int BUS_AW      = 8;
    localparam int SYNC_DEPTH  = 2;

    localparam int unsigned OFS_PINS  = 32'h00;
    localparam int unsigned OFS_LATCH = 32'h04;
    localparam int unsigned OFS_DIR   = 32'h08;
    localparam int unsigned OFS_POL   = 32'h0C;
    localparam int unsigned OFS_MASK  = 32'h10;
    localparam int unsigned OFS_STAT  = 32'h14;
    localparam int unsigned OFS_GATE  = 32'h18;

    typedef logic [LINE_CNT-1:0] lvec_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PINS,
        SEL_LATCH,
        SEL_DIR,
        SEL_POL,
        SEL_MASK,
        SEL_STAT,
        SEL_GATE
    } reg_sel_e;

    typedef struct packed {
        lvec_t latch;
        lvec_t dir;
        lvec_t pol;
        lvec_t mask;
        lvec_t gate;
    } cfg_t;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_PINS:  s = SEL_PINS;
            OFS_LATCH: s = SEL_LATCH;
            OFS_DIR:   s = SEL_DIR;
            OFS_POL:   s = SEL_POL;
            OFS_MASK:  s = SEL_MASK;
            OFS_STAT:  s = SEL_STAT;
            OFS_GATE:  s = SEL_GATE;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Per line: polarity 1 picks a 0->1 transition, polarity 0 picks 1->0.
    function automatic lvec_t edge_hits(input lvec_t pol, input lvec_t cur,
                                        input lvec_t prev);
        return (pol & cur & ~prev) | (~pol & ~cur & prev);
    endfunction

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync
    import gpio_edge_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  lvec_t pad_in,
    output lvec_t cur,
    output lvec_t prev
);

    lvec_t chain [STAGES];
    lvec_t prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= pad_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    // One-cycle history of the synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= chain[STAGES-1];
    end

    assign cur  = chain[STAGES-1];
    assign prev = prev_q;

endmodule

// File: rtl/gpio_edge_cfg.sv
module gpio_edge_cfg
    import gpio_edge_pkg::*;
#(
    parameter int DATA_W = BUS_DW,
    parameter int ADDR_W = BUS_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output reg_sel_e          acc_sel,
    output cfg_t              cfg,
    output lvec_t             clr_mask
);

    localparam int HI_BITS = DATA_W - LINE_CNT;

    cfg_t  cfg_q;
    logic  wr_en;
    lvec_t wval;
    logic  unused_hi;

    assign acc_sel   = decode_ofs(32'(bus_addr));
    assign wr_en     = bus_sel & bus_wr;
    assign wval      = bus_wdata[LINE_CNT-1:0];
    assign unused_hi = ^bus_wdata[LINE_CNT +: HI_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '1;
        end else if (wr_en) begin
            case (acc_sel)
                SEL_LATCH: cfg_q.latch <= wval;
                SEL_DIR:   cfg_q.dir   <= wval;
                SEL_POL:   cfg_q.pol   <= wval;
                SEL_MASK:  cfg_q.mask  <= wval;
                SEL_GATE:  cfg_q.gate  <= wval;
                default:   ;
            endcase
        end
    end

    assign cfg      = cfg_q;
    assign clr_mask = (wr_en && acc_sel == SEL_STAT) ? wval : '0;

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status
    import gpio_edge_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lvec_t cur,
    input  lvec_t prev,
    input  cfg_t  cfg,
    input  lvec_t clr_mask,
    output lvec_t status,
    output logic  irq
);

    lvec_t status_q;
    lvec_t hit;

    // Qualify detected edges by input direction and an open mask.
    assign hit = edge_hits(cfg.pol, cur, prev) & cfg.dir & ~cfg.mask;

    // A fresh event outranks a clear aimed at the same bit.
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | hit;
    end

    assign status = status_q;
    assign irq    = |status_q;

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int DATA_W      = BUS_DW,
    parameter int ADDR_W      = BUS_AW,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [LINE_CNT-1:0] pad_in,
    output logic [LINE_CNT-1:0] pad_out,
    output logic [LINE_CNT-1:0] pad_oe,
    output logic                irq
);

    reg_sel_e acc_sel;
    cfg_t     cfg;
    lvec_t    clr_mask;
    lvec_t    cur;
    lvec_t    prev;
    lvec_t    status;
    lvec_t    rd_val;

    gpio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .cur    (cur),
        .prev   (prev)
    );

    gpio_edge_cfg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .acc_sel   (acc_sel),
        .cfg       (cfg),
        .clr_mask  (clr_mask)
    );

    gpio_edge_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur),
        .prev     (prev),
        .cfg      (cfg),
        .clr_mask (clr_mask),
        .status   (status),
        .irq      (irq)
    );

    always_comb begin
        case (acc_sel)
            SEL_PINS:  rd_val = cur & cfg.gate;
            SEL_LATCH: rd_val = cfg.latch;
            SEL_DIR:   rd_val = cfg.dir;
            SEL_POL:   rd_val = cfg.pol;
            SEL_MASK:  rd_val = cfg.mask;
            SEL_STAT:  rd_val = status;
            SEL_GATE:  rd_val = cfg.gate;
            default:   rd_val = '0;
        endcase
    end

    assign bus_rdata = DATA_W'(rd_val);
    assign pad_oe    = ~cfg.dir;
    assign pad_out   = cfg.latch & ~cfg.dir;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int DATA_W = BUS_DW,
    parameter int ADDR_W = BUS_AW
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [LINE_CNT-1:0] pad_in,
    input logic [LINE_CNT-1:0] pad_out,
    input logic [LINE_CNT-1:0] pad_oe,
    input logic                irq
);

    logic stat_wr;
    logic pins_wr;

    assign stat_wr = bus_sel && bus_wr && (32'(bus_addr) == OFS_STAT);
    assign pins_wr = bus_sel && bus_wr && (32'(bus_addr) == OFS_PINS);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pad_oe == '0));

    // R3
    pad_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    // R6
    irq_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !(&$past(pad_oe)));

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(stat_wr));

    // R10
    ro_write_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pins_wr) |-> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
    import gpio_edge_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    // Bench model state
    logic [15:0] m_s1, m_s2, m_prev, m_out, m_dir, m_pol, m_mask, m_stat, m_gate;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return {16'h0, m_s2 & m_gate};
            8'h04: return {16'h0, m_out};
            8'h08: return {16'h0, m_dir};
            8'h0C: return {16'h0, m_pol};
            8'h10: return {16'h0, m_mask};
            8'h14: return {16'h0, m_stat};
            8'h18: return {16'h0, m_gate};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_req(input logic [7:0] a);
        case (a)
            8'h00: return "R4";
            8'h14: return "R7";
            8'h04, 8'h08, 8'h0C, 8'h10, 8'h18: return "R2";
            default: return "R10";
        endcase
    endfunction

    // Model update from the requirements
    always @(posedge clk) begin
        logic [15:0] ev, clr, wv;
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0;
            m_out <= '1; m_dir <= '1; m_pol <= '1; m_mask <= '1; m_gate <= '1;
        end else begin
            ev  = m_dir & ~m_mask & ((m_pol & m_s2 & ~m_prev) | (~m_pol & ~m_s2 & m_prev));
            wv  = bus_wdata[15:0];
            clr = (bus_sel && bus_wr && bus_addr == 8'h14) ? wv : 16'h0;
            m_stat <= (m_stat & ~clr) | ev;
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    8'h04: m_out  <= wv;
                    8'h08: m_dir  <= wv;
                    8'h0C: m_pol  <= wv;
                    8'h10: m_mask <= wv;
                    8'h18: m_gate <= wv;
                    default: ;
                endcase
            end
            m_s1 <= pad_in; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    // Cycle monitor at mid-cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8", {31'h0, irq}, {31'h0, |m_stat});
            check("R3", {16'h0, pad_oe}, {16'h0, ~m_dir});
            check("R3", {16'h0, pad_out}, {16'h0, m_out & ~m_dir});
            if (bus_sel && !bus_wr)
                check(rd_req(bus_addr), bus_rdata, exp_rd(bus_addr));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_sel = 0; bus_wr = 0;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        check(req, bus_rdata, exp);
    endtask

    task automatic set_pad(input logic [15:0] v);
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; pad_in = v;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        @(negedge clk);
        check("R1", {31'h0, irq}, 32'h0);
        check("R1", {16'h0, pad_oe}, 32'h0);
        rd(8'h00, 32'h0000, "R1");
        rd(8'h04, 32'hFFFF, "R1");
        rd(8'h08, 32'hFFFF, "R1");
        rd(8'h0C, 32'hFFFF, "R1");
        rd(8'h10, 32'hFFFF, "R1");
        rd(8'h14, 32'h0000, "R1");
        rd(8'h18, 32'hFFFF, "R1");

        // R2 storage, upper bits dropped
        wr(8'h04, 32'hDEAD_1234);
        rd(8'h04, 32'h0000_1234, "R2");

        // R3 switch low byte to output: latch appears at once
        wr(8'h08, 32'h0000_FF00);
        @(negedge clk);
        check("R3", {16'h0, pad_oe}, 32'h0000_00FF);
        check("R3", {16'h0, pad_out}, 32'h0000_0034);
        wr(8'h08, 32'h0000_FFFF);

        // R4 gated, two-stage synchronized input read
        wr(8'h18, 32'h0000_0FF0);
        set_pad(16'hA5A5);
        rd(8'h00, 32'h0000_0000, "R4");
        rd(8'h00, 32'h0000_05A0, "R4");
        wr(8'h18, 32'h0000_FFFF);

        // R5 polarity: line0 rising, line1 falling, both unmasked
        wr(8'h0C, 32'h0000_FFFD);
        wr(8'h10, 32'h0000_FFFC);
        idle(4);
        wr(8'h14, 32'h0000_FFFF);
        set_pad(16'hA5A7);           // line1 rises: wrong edge
        idle(4);
        rd(8'h14, 32'h0000_0000, "R5");
        set_pad(16'hA5A5);           // line1 falls
        idle(4);
        rd(8'h14, 32'h0000_0002, "R5");
        check("R8", {31'h0, irq}, 32'h1);
        set_pad(16'hA5A4);           // line0 falls: wrong edge
        idle(4);
        rd(8'h14, 32'h0000_0002, "R5");
        set_pad(16'hA5A5);           // line0 rises
        idle(4);
        rd(8'h14, 32'h0000_0003, "R5");
        rd(8'h14, 32'h0000_0003, "R11");

        // R7 / R8 write-one-to-clear
        wr(8'h14, 32'h0000_0001);
        rd(8'h14, 32'h0000_0002, "R7");
        check("R8", {31'h0, irq}, 32'h1);
        wr(8'h14, 32'h0000_0002);
        rd(8'h14, 32'h0000_0000, "R7");
        check("R8", {31'h0, irq}, 32'h0);

        // R6 masked input (line2) and unmasked output (line3) never latch
        wr(8'h10, 32'h0000_FFF4);
        wr(8'h08, 32'h0000_FFF7);
        set_pad(16'hA5A9);           // line2 falls, line3 rises
        idle(4);
        rd(8'h14, 32'h0000_0000, "R6");
        wr(8'h08, 32'h0000_FFFF);
        wr(8'h10, 32'h0000_FFFC);

        // R9 edge and clear at the same clock edge
        set_pad(16'hA5A8);           // line0 low
        idle(4);
        wr(8'h14, 32'h0000_FFFF);
        @(posedge clk); #1;
        pad_in = 16'hA5A9;           // line0 rises, edge hits two edges later
        @(posedge clk);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = 8'h14; bus_wdata = 32'h0000_0001;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
        rd(8'h14, 32'h0000_0001, "R9");
        check("R9", {31'h0, irq}, 32'h1);
        wr(8'h14, 32'h0000_FFFF);

        // R10 ignored writes and unmapped reads
        wr(8'h00, 32'h0000_0000);
        wr(8'h1C, 32'h0000_0000);
        wr(8'h40, 32'h0000_0000);
        rd(8'h18, 32'h0000_FFFF, "R10");
        rd(8'h10, 32'h0000_FFFC, "R10");
        rd(8'h04, 32'h0000_1234, "R10");
        rd(8'h1C, 32'h0000_0000, "R10");
        rd(8'h02, 32'h0000_0000, "R10");

        // Random traffic scored by the cycle monitor
        for (int i = 0; i < RAND_CYCLES; i++) begin
            @(posedge clk); #1;
            bus_sel   = ($urandom % 3) != 0;
            bus_wr    = ($urandom % 2) == 1;
            case ($urandom % 9)
                0: bus_addr = 8'h00;  1: bus_addr = 8'h04;
                2: bus_addr = 8'h08;  3: bus_addr = 8'h0C;
                4: bus_addr = 8'h10;  5: bus_addr = 8'h14;
                6: bus_addr = 8'h18;  7: bus_addr = 8'h1C;
                default: bus_addr = 8'($urandom);
            endcase
            bus_wdata = $urandom;
            if (($urandom % 4) == 0) pad_in = pad_in ^ 16'($urandom);
        end
        idle(4);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule